// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one W-bit integer by another over a fixed number of clock cycles, one quotient bit per cycle. It keeps a single double-width working register. The magnitude of the dividend is loaded into its lower half, already shifted left by one place. On each cycle the divisor is trial-subtracted from the upper half. The difference is kept only if it is not negative, and the new quotient bit enters at the low end as the register moves left. When the last bit is in, the lower half holds the quotient and the upper half, moved back right by one place, holds the remainder.

A front stage lets the same unsigned core serve signed operands. It takes the magnitudes of both operands and records the signs. A back stage then negates the quotient when the operand signs differ and gives the remainder the sign of the dividend. The datapath does not stop on a zero divisor. It runs the normal sequence, then reports the case with a flag beside the completion pulse and returns fixed results that software can test for.

Top module: `seq_div`

## Requirements
- R1: After reset, done_o and div_zero_o are 0, and quotient_o and remainder_o are 0.
- R2: A start_i sampled high at a clock edge while no division is running is accepted. done_o is then high for exactly one cycle, the W+1-th cycle after that edge, and low at all other times.
- R3: With signed_i = 0, quotient_o is the floor of dividend_i / divisor_i and remainder_o is dividend_i mod divisor_i, both operands unsigned.
- R4: With signed_i = 1, the operands are two's complement. quotient_o is the quotient rounded toward zero, so its sign is negative exactly when the operand signs differ.
- R5: With signed_i = 1, remainder_o has the sign of the dividend, and its magnitude is |dividend| mod |divisor|. For example -7/2 gives -3 remainder -1, and 7/-2 gives -3 remainder +1.
- R6: With signed_i = 1, the most negative value divided by -1 gives the most negative value as quotient (the result wraps) and 0 as remainder.
- R7: When divisor_i is 0, div_zero_o is high together with done_o, quotient_o is all ones and remainder_o equals dividend_i as given, in both modes. div_zero_o is low whenever done_o is low.
- R8: A start_i that arrives while a division is running is ignored, and the running division completes with its original operands and timing.
- R9: quotient_o and remainder_o keep their values after done_o until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division with the present operands |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend_i | input | W | Dividend |
| divisor_i | input | W | Divisor |
| quotient_o | output | W | Quotient |
| remainder_o | output | W | Remainder |
| done_o | output | 1 | One-cycle pulse when results are valid |
| div_zero_o | output | 1 | Divisor was zero, valid with done_o |

## Verification
The hardest cases to reach from the ports are those where the trial difference sits right at the boundary in the top bits. Examples are a divisor with its top bit set, a most-negative dividend whose magnitude needs every bit, and the wrap of the most negative value divided by -1. Random operands rarely produce these, so the stimulus adds directed operands built from all-ones, top-bit-only and near-boundary values in both modes. A second start is also pulsed in the middle of a running division to show that it is ignored.

// File: rtl/seq_div_pkg.sv
package seq_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } div_state_e;
endpackage

// File: rtl/seq_div_prep.sv
module seq_div_prep #(
  parameter int W = 16
) (
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_q_o,
  output logic         neg_r_o,
  output logic         div_zero_o
);
  logic a_neg, b_neg;

  assign a_neg      = signed_i & dividend_i[W-1];
  assign b_neg      = signed_i & divisor_i[W-1];
  assign mag_a_o    = a_neg ? (~dividend_i + 1'b1) : dividend_i;
  assign mag_b_o    = b_neg ? (~divisor_i + 1'b1) : divisor_i;
  assign neg_q_o    = a_neg ^ b_neg;
  assign neg_r_o    = a_neg;
  assign div_zero_o = (divisor_i == '0);
endmodule

// File: rtl/seq_div_core.sv
module seq_div_core
  import seq_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] mag_a_i,
  input  logic [W-1:0] mag_b_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam int AW = 2 * W + 1;

  div_state_e      st_q;
  logic [CW-1:0]   cnt_q;
  logic [AW-1:0]   acc_q, acc_step;
  logic [W-1:0]    dvs_q;
  logic [W:0]      hi;
  logic [W+1:0]    diff;
  logic            last;

  assign hi   = acc_q[AW-1:W];
  assign diff = {1'b0, hi} - {2'b00, dvs_q};
  assign last = (cnt_q == CW'(W - 1));

  // keep difference only when non-negative; quotient bit enters at bit 0
  always_comb begin
    if (diff[W+1]) acc_step = {acc_q[AW-2:0], 1'b0};
    else           acc_step = {diff[W-1:0], acc_q[W-1:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      acc_q <= '0;
      dvs_q <= '0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          acc_q <= acc_step;
          cnt_q <= cnt_q + 1'b1;
          if (last) st_q <= ST_DONE;
        end
        default: begin
          if (load_i) begin
            acc_q <= {{W{1'b0}}, mag_a_i, 1'b0};
            dvs_q <= mag_b_i;
            cnt_q <= '0;
            st_q  <= ST_RUN;
          end else begin
            st_q  <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign busy_o = (st_q == ST_RUN);
  assign fin_o  = (st_q == ST_DONE);
  assign quot_o = acc_q[W-1:0];
  assign rem_o  = acc_q[AW-1:W+1];

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));

  p_fin_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !fin_o);

  // partial remainder stays below twice the divisor (restoring invariant)
  p_partial_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && dvs_q != '0) |-> ({1'b0, hi} < {1'b0, dvs_q, 1'b0}));
endmodule

// File: rtl/seq_div_fix.sv
module seq_div_fix #(
  parameter int W = 16
) (
  input  logic         neg_q_i,
  input  logic         neg_r_i,
  input  logic         div_zero_i,
  input  logic [W-1:0] raw_a_i,
  input  logic [W-1:0] quot_i,
  input  logic [W-1:0] rem_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  always_comb begin
    if (div_zero_i) begin
      quot_o = '1;
      rem_o  = raw_a_i;
    end else begin
      quot_o = neg_q_i ? (~quot_i + 1'b1) : quot_i;
      rem_o  = neg_r_i ? (~rem_i + 1'b1) : rem_i;
    end
  end
endmodule

// File: rtl/seq_div.sv
module seq_div #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o,
  output logic         done_o,
  output logic         div_zero_o
);
  logic [W-1:0] mag_a, mag_b, core_q, core_r, raw_a_q;
  logic         neg_q, neg_r, dz, busy, fin, accept;
  logic         neg_q_q, neg_r_q, dz_q;

  assign accept = start_i & ~busy;

  seq_div_prep #(.W(W)) u_prep (
    .signed_i   (signed_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .mag_a_o    (mag_a),
    .mag_b_o    (mag_b),
    .neg_q_o    (neg_q),
    .neg_r_o    (neg_r),
    .div_zero_o (dz)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
      dz_q    <= 1'b0;
      raw_a_q <= '0;
    end else if (accept) begin
      neg_q_q <= neg_q;
      neg_r_q <= neg_r;
      dz_q    <= dz;
      raw_a_q <= dividend_i;
    end
  end

  seq_div_core #(.W(W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .mag_a_i (mag_a),
    .mag_b_i (mag_b),
    .busy_o  (busy),
    .fin_o   (fin),
    .quot_o  (core_q),
    .rem_o   (core_r)
  );

  seq_div_fix #(.W(W)) u_fix (
    .neg_q_i    (neg_q_q),
    .neg_r_i    (neg_r_q),
    .div_zero_i (dz_q),
    .raw_a_i    (raw_a_q),
    .quot_i     (core_q),
    .rem_i      (core_r),
    .quot_o     (quotient_o),
    .rem_o      (remainder_o)
  );

  assign done_o     = fin;
  assign div_zero_o = fin & dz_q;

  p_dz_with_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_zero_o |-> done_o);

  p_busy_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |=> ($stable(raw_a_q) && $stable(dz_q) && $stable(neg_q_q)));

  p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)));
endmodule

// File: tb/seq_div_bench.sv
module seq_div_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_r = 1'b0;
  logic         sgn_r = 1'b0;
  logic [W-1:0] a_r = '0, b_r = '0;
  logic [W-1:0] quotient, remainder;
  logic         done, div_zero;

  int unsigned  cyc = 0;
  int           errors = 0;
  int           checks = 0;
  bit           finished = 0;

  bit           pending = 0;
  int unsigned  due = 0;
  logic [W-1:0] exp_q, exp_r;
  logic         exp_dz;
  string        tag_r = "";

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seq_div #(.W(W)) u_seq_div (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start_r),
    .signed_i    (sgn_r),
    .dividend_i  (a_r),
    .divisor_i   (b_r),
    .quotient_o  (quotient),
    .remainder_o (remainder),
    .done_o      (done),
    .div_zero_o  (div_zero)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h (t=%0t)", req, what, act, expv, $time);
    end
  endtask

  // behavioural model of the expected results
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
    longint sa, sb, q, r;
    if (b == '0) begin
      exp_q = '1; exp_r = a; exp_dz = 1'b1;
    end else begin
      if (s) begin
        sa = longint'($signed(a));
        sb = longint'($signed(b));
      end else begin
        sa = longint'({1'b0, a});
        sb = longint'({1'b0, b});
      end
      q = sa / sb;
      r = sa % sb;
      exp_q = q[W-1:0]; exp_r = r[W-1:0]; exp_dz = 1'b0;
    end
  endtask

  // cycle-by-cycle monitor of done, flag and results
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (pending && cyc == due) begin
        chk(done === 1'b1, "R2", "done at due cycle", W'(done), W'(1));
        chk(quotient === exp_q, tag_r, "quotient", quotient, exp_q);
        chk(remainder === exp_r, tag_r, "remainder", remainder, exp_r);
        chk(div_zero === exp_dz, "R7", "div_zero", W'(div_zero), W'(exp_dz));
        pending = 0;
      end else begin
        chk(done === 1'b0, "R2", "done off-cycle", W'(done), W'(0));
        chk(div_zero === 1'b0, "R7", "div_zero without done", W'(div_zero), W'(0));
      end
    end
  end

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic s, input string tag, input bit poke);
    @(negedge clk);
    a_r = a; b_r = b; sgn_r = s; start_r = 1'b1;
    model(a, b, s);
    tag_r = tag;
    due = cyc + W + 1;
    pending = 1;
    @(negedge clk);
    start_r = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (poke && i == 3) begin
        // R8: a second start while running, different operands
        a_r = ~a; b_r = b + 1'b1; sgn_r = ~s; start_r = 1'b1;
      end else begin
        start_r = 1'b0;
      end
      @(negedge clk);
    end
    start_r = 1'b0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(done === 1'b0, "R1", "done", W'(done), W'(0));
    chk(div_zero === 1'b0, "R1", "div_zero", W'(div_zero), W'(0));
    chk(quotient === '0, "R1", "quotient", quotient, '0);
    chk(remainder === '0, "R1", "remainder", remainder, '0);

    // R3 unsigned directed
    run_op(16'd7, 16'd2, 1'b0, "R3", 0);
    run_op(16'hFFFF, 16'h8000, 1'b0, "R3", 0);
    run_op(16'hFFFF, 16'hFFFF, 1'b0, "R3", 0);
    run_op(16'hFFFF, 16'd1, 1'b0, "R3", 0);
    run_op(16'h7FFF, 16'hFFFE, 1'b0, "R3", 0);
    run_op(16'h8001, 16'h8000, 1'b0, "R3", 0);
    // R4 R5 signed sign rules
    run_op(-16'sd7, 16'sd2, 1'b1, "R4 R5", 0);
    run_op(16'sd7, -16'sd2, 1'b1, "R4 R5", 0);
    run_op(-16'sd7, -16'sd2, 1'b1, "R4 R5", 0);
    run_op(16'h8000, 16'h7FFF, 1'b1, "R4 R5", 0);
    run_op(16'h8000, 16'd3, 1'b1, "R4 R5", 0);
    // R6 wrap
    run_op(16'h8000, 16'hFFFF, 1'b1, "R6", 0);
    // R7 divide by zero
    run_op(16'h1234, 16'h0000, 1'b0, "R7", 0);
    run_op(16'h8765, 16'h0000, 1'b1, "R7", 0);
    // R8 start while busy
    run_op(16'd1000, 16'd7, 1'b0, "R8", 1);
    run_op(-16'sd1000, 16'sd7, 1'b1, "R8", 1);
    // R9 hold after done
    run_op(16'd500, 16'd9, 1'b0, "R3", 0);
    repeat (4) @(negedge clk);
    chk(quotient === 16'd55, "R9", "held quotient", quotient, 16'd55);
    chk(remainder === 16'd5, "R9", "held remainder", remainder, 16'd5);

    // random, both modes, with boundary-biased operands
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom);
      case (n % 8)
        0: b = W'($urandom_range(1, 15));
        1: a = 16'h8000;
        2: b = 16'hFFFF;
        3: b = b | 16'h8000;
        default: ;
      endcase
      if (n % 2 == 0) run_op(a, b, 1'b0, "R3", 0);
      else            run_op(a, b, 1'b1, "R4 R5", 0);
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule